// File: doc/BRIEF.md
# Isolated Indirect Branch Target Predictor

This block predicts targets for indirect branches on one core that runs two hardware threads. A lookup port presents a branch address with its decoded branch class, the requesting thread and the privilege mode. One clock later the block returns a hit flag and a predicted target. A training port writes resolved targets back into a small direct-mapped table. Each entry records which thread trained it and in which privilege mode.

Three control inputs limit which entries may supply a prediction. The isolation input stops a thread from using entries that its sibling trained. The restriction input stops host-mode lookups from using entries trained in guest mode. The barrier input invalidates the whole table, so nothing trained before the barrier can predict a later branch. Each core instantiates its own copy and has no path to any other core's entries.

Top module: `ibtp_core`

## Requirements
- R1: Only the branch class codes 1 (near indirect call), 2 (near indirect jump) and 3 (near return) may consult the table. A lookup with any other code (0, 4..7) yields pred_hit=0.
- R2: With both control inputs low, an entry trained by one thread hits for a lookup from the other thread.
- R3: With ctl_isolate=1, a lookup never hits an entry whose thread tag differs from lk_thread. Entries of the requesting thread still hit.
- R4: ctl_barrier=1 clears every valid bit at the next clock edge. A lookup presented in the same cycle as the barrier returns a miss.
- R5: Mode encoding is 1=host (more privileged) and 0=guest. With ctl_restrict=1, a host lookup never hits an entry trained in guest mode. Host lookups on host-trained entries, and guest lookups on any entry, are unaffected.
- R6: pred_valid is 1 in exactly the cycle after a cycle with lk_valid=1, and 0 otherwise.
- R7: On a hit, pred_target equals the target of the matching entry. On a miss, pred_target is 0.
- R8: A training request with class code 1..3 writes the entry indexed by pc[3:0]. The entry stores tag pc[11:4], the thread, the mode and the target, and is visible to lookups from the following cycle.
- R9: A training request with a class code outside 1..3 leaves the table unchanged.
- R10: After reset, pred_valid, pred_hit and pred_target are 0, and all entries are invalid.
- R11: A lookup whose index matches but whose tag differs misses. Training a new address to an occupied index replaces the old entry.
- R12: A barrier overrides a training request in the same cycle, so that entry stays invalid. A lookup and a training request to the same index in one cycle return the entry's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_class | input | 3 | Decoded branch class of the lookup |
| lk_pc | input | 32 | Branch address of the lookup |
| lk_thread | input | 1 | Requesting thread |
| lk_host | input | 1 | Lookup privilege mode, 1 = host |
| tr_valid | input | 1 | Training request |
| tr_class | input | 3 | Decoded branch class of the trained branch |
| tr_pc | input | 32 | Branch address being trained |
| tr_target | input | 32 | Resolved target |
| tr_thread | input | 1 | Thread that resolved the branch |
| tr_host | input | 1 | Privilege mode at resolution |
| ctl_isolate | input | 1 | Block hits on sibling-trained entries |
| ctl_restrict | input | 1 | Block host hits on guest-trained entries |
| ctl_barrier | input | 1 | Invalidate the whole table |
| pred_valid | output | 1 | Lookup result is present |
| pred_hit | output | 1 | Prediction available |
| pred_target | output | 32 | Predicted target, 0 on a miss |

## Verification
The bench trains one entry from one thread in guest mode. It then looks that entry up from the other thread, from host mode, and under each control. A design that ignored the thread or mode tags would hit where a miss is expected. A design that inverted the mode comparison would block guest lookups or host-trained entries. Aliasing addresses that share an index check that the tag is compared and that a newer entry replaces an older one. Same-cycle collisions are tested directly: barrier with lookup, barrier with training, and lookup with training. A design with the wrong priority or read order would return a stale hit or the freshly written target.

// File: rtl/ibtp_pkg.sv
package ibtp_pkg;
  parameter int ADDR_W = 32;
  parameter int IDX_W  = 4;
  parameter int TAG_W  = 8;
  parameter int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    BR_NONE     = 3'd0,
    BR_IND_CALL = 3'd1,
    BR_IND_JMP  = 3'd2,
    BR_NEAR_RET = 3'd3,
    BR_COND     = 3'd4,
    BR_DIR_CALL = 3'd5,
    BR_FAR      = 3'd6,
    BR_OTHER    = 3'd7
  } br_class_e;

  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic              thr;
    logic              host;
    logic [ADDR_W-1:0] tgt;
  } entry_t;

  function automatic logic uses_predictor(logic [CLS_W-1:0] cls);
    return (cls == BR_IND_CALL) || (cls == BR_IND_JMP) || (cls == BR_NEAR_RET);
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(logic [ADDR_W-1:0] pc);
    return pc[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] pc);
    return pc[IDX_W+TAG_W-1:IDX_W];
  endfunction
endpackage

// File: rtl/ibtp_table.sv
module ibtp_table
  import ibtp_pkg::*;
#(
  parameter int ENTRIES = 1 << IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  entry_t             wr_entry,
  input  logic [IDX_W-1:0]   rd_idx,
  output entry_t             rd_entry,
  output logic [ENTRIES-1:0] valid_vec
);
  entry_t mem [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (flush) begin
        mem[i].vld <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        mem[i] <= wr_entry;
      end
    end
    assign valid_vec[i] = mem[i].vld;
  end

  assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/ibtp_match.sv
module ibtp_match
  import ibtp_pkg::*;
(
  input  entry_t           ent,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic             lk_thread,
  input  logic             lk_host,
  input  logic             isolate,
  input  logic             restrict_spec,
  output logic             tag_hit,
  output logic             iso_block,
  output logic             priv_block
);
  always_comb begin
    tag_hit    = ent.vld && (ent.tag == lk_tag);
    iso_block  = isolate && (ent.thr != lk_thread);
    priv_block = restrict_spec && lk_host && !ent.host;
  end
endmodule

// File: rtl/ibtp_core.sv
module ibtp_core
  import ibtp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [CLS_W-1:0]  lk_class,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_thread,
  input  logic              lk_host,
  input  logic              tr_valid,
  input  logic [CLS_W-1:0]  tr_class,
  input  logic [ADDR_W-1:0] tr_pc,
  input  logic [ADDR_W-1:0] tr_target,
  input  logic              tr_thread,
  input  logic              tr_host,
  input  logic              ctl_isolate,
  input  logic              ctl_restrict,
  input  logic              ctl_barrier,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target
);
  localparam int ENTRIES = 1 << IDX_W;

  entry_t             rd_entry;
  entry_t             wr_entry;
  logic [ENTRIES-1:0] valid_vec;
  logic               do_train;
  logic               lk_eligible;
  logic               tag_hit, iso_block, priv_block;
  logic               hit_next;

  assign do_train = tr_valid && uses_predictor(tr_class) && !ctl_barrier;
  assign lk_eligible = lk_valid && uses_predictor(lk_class);

  always_comb begin
    wr_entry.vld  = 1'b1;
    wr_entry.tag  = tag_of(tr_pc);
    wr_entry.thr  = tr_thread;
    wr_entry.host = tr_host;
    wr_entry.tgt  = tr_target;
  end

  ibtp_table #(.ENTRIES(ENTRIES)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (ctl_barrier),
    .wr_en    (do_train),
    .wr_idx   (idx_of(tr_pc)),
    .wr_entry (wr_entry),
    .rd_idx   (idx_of(lk_pc)),
    .rd_entry (rd_entry),
    .valid_vec(valid_vec)
  );

  ibtp_match u_match (
    .ent          (rd_entry),
    .lk_tag       (tag_of(lk_pc)),
    .lk_thread    (lk_thread),
    .lk_host      (lk_host),
    .isolate      (ctl_isolate),
    .restrict_spec(ctl_restrict),
    .tag_hit      (tag_hit),
    .iso_block    (iso_block),
    .priv_block   (priv_block)
  );

  assign hit_next = lk_eligible && tag_hit && !iso_block && !priv_block && !ctl_barrier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_target <= '0;
    end else begin
      pred_valid  <= lk_valid;
      pred_hit    <= hit_next;
      pred_target <= hit_next ? rd_entry.tgt : '0;
    end
  end
endmodule

// File: rtl/ibtp_core_chk.sv
module ibtp_core_chk
  import ibtp_pkg::*;
#(
  parameter int ENTRIES = 1 << IDX_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [CLS_W-1:0]   lk_class,
  input logic               lk_thread,
  input logic               lk_host,
  input logic               tr_valid,
  input logic [CLS_W-1:0]   tr_class,
  input logic               ctl_isolate,
  input logic               ctl_restrict,
  input logic               ctl_barrier,
  input logic               pred_valid,
  input logic               pred_hit,
  input logic [ADDR_W-1:0]  pred_target,
  input entry_t             rd_entry,
  input logic [ENTRIES-1:0] valid_vec
);
  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !uses_predictor(lk_class) |=> !pred_hit);

  p_isolate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && ctl_isolate && rd_entry.vld && (rd_entry.thr != lk_thread) |=> !pred_hit);

  p_barrier_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_barrier |=> (valid_vec == '0) && !pred_hit);

  p_restrict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && ctl_restrict && lk_host && rd_entry.vld && !rd_entry.host |=> !pred_hit);

  p_latency_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);

  p_latency_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> pred_target == '0);

  p_hit_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |-> pred_valid);

  p_ignore_train_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_barrier && !(tr_valid && uses_predictor(tr_class)) |=> $stable(valid_vec));
endmodule

bind ibtp_core ibtp_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_valid    (lk_valid),
  .lk_class    (lk_class),
  .lk_thread   (lk_thread),
  .lk_host     (lk_host),
  .tr_valid    (tr_valid),
  .tr_class    (tr_class),
  .ctl_isolate (ctl_isolate),
  .ctl_restrict(ctl_restrict),
  .ctl_barrier (ctl_barrier),
  .pred_valid  (pred_valid),
  .pred_hit    (pred_hit),
  .pred_target (pred_target),
  .rd_entry    (rd_entry),
  .valid_vec   (valid_vec)
);

// File: tb/ibtp_core_test.sv
module ibtp_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_thread = 0, lk_host = 0;
  logic [2:0]  lk_class = 0;
  logic [31:0] lk_pc = 0;
  logic        tr_valid = 0, tr_thread = 0, tr_host = 0;
  logic [2:0]  tr_class = 0;
  logic [31:0] tr_pc = 0, tr_target = 0;
  logic        ctl_isolate = 0, ctl_restrict = 0, ctl_barrier = 0;
  logic        pred_valid, pred_hit;
  logic [31:0] pred_target;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ibtp_core uut (.*);

  localparam logic [1:0] OP_TR = 2'd0, OP_LK = 2'd1, OP_BAR = 2'd2;

  function automatic logic [73:0] mk(logic [1:0] op, logic [2:0] cls, logic [31:0] pc,
      logic thr, logic host, logic iso, logic rs, logic [31:0] tgt, logic eh);
    return {op, cls, pc, thr, host, iso, rs, tgt, eh};
  endfunction

  localparam int NV = 19;
  localparam logic [73:0] VEC [NV] = '{
    mk(OP_TR,  3'd1, 32'h15,  0, 0, 0, 0, 32'h1000_0000, 0), // train T0 guest
    mk(OP_LK,  3'd1, 32'h15,  1, 0, 0, 0, 32'h1000_0000, 1), // R2 sibling shares
    mk(OP_LK,  3'd1, 32'h15,  1, 0, 1, 0, 32'h0,         0), // R3 sibling blocked
    mk(OP_LK,  3'd1, 32'h15,  0, 0, 1, 0, 32'h1000_0000, 1), // R3 own thread ok
    mk(OP_LK,  3'd1, 32'h15,  0, 1, 0, 1, 32'h0,         0), // R5 host on guest entry
    mk(OP_LK,  3'd1, 32'h15,  0, 1, 0, 0, 32'h1000_0000, 1), // R5 control off
    mk(OP_LK,  3'd1, 32'h15,  0, 0, 0, 1, 32'h1000_0000, 1), // R5 guest lookup ok
    mk(OP_LK,  3'd4, 32'h15,  0, 0, 0, 0, 32'h0,         0), // R1 cond bypass
    mk(OP_TR,  3'd5, 32'h26,  0, 0, 0, 0, 32'h2222,      0), // R9 ineligible train
    mk(OP_LK,  3'd1, 32'h26,  0, 0, 0, 0, 32'h0,         0), // R9 miss
    mk(OP_TR,  3'd3, 32'h26,  1, 1, 0, 0, 32'h3333_0000, 0), // R8 return train host
    mk(OP_LK,  3'd2, 32'h26,  0, 1, 0, 1, 32'h3333_0000, 1), // R5 host on host entry
    mk(OP_LK,  3'd2, 32'h126, 0, 1, 0, 0, 32'h0,         0), // R11 tag mismatch
    mk(OP_TR,  3'd2, 32'h126, 0, 0, 0, 0, 32'h4444,      0), // R11 replace
    mk(OP_LK,  3'd2, 32'h26,  0, 0, 0, 0, 32'h0,         0), // R11 evicted
    mk(OP_LK,  3'd3, 32'h126, 1, 0, 0, 0, 32'h4444,      1), // R8 new entry
    mk(OP_BAR, 3'd0, 32'h0,   0, 0, 0, 0, 32'h0,         0), // R4 barrier
    mk(OP_LK,  3'd1, 32'h15,  0, 0, 0, 0, 32'h0,         0), // R4 flushed
    mk(OP_LK,  3'd2, 32'h126, 0, 0, 0, 0, 32'h0,         0)  // R4 flushed
  };

  task automatic idle();
    lk_valid = 0; tr_valid = 0; ctl_barrier = 0; ctl_isolate = 0; ctl_restrict = 0;
    lk_class = 0; tr_class = 0;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic train(logic [2:0] cls, logic [31:0] pc, logic thr, logic host, logic [31:0] tgt);
    @(negedge clk);
    tr_valid = 1; tr_class = cls; tr_pc = pc; tr_thread = thr; tr_host = host; tr_target = tgt;
    @(negedge clk);
    idle();
  endtask

  task automatic lookup(logic [31:0] pc, string req, logic eh, logic [31:0] et);
    @(negedge clk);
    lk_valid = 1; lk_class = 3'd1; lk_pc = pc; lk_thread = 0; lk_host = 0;
    @(negedge clk);
    idle();
    check(req, {31'd0, pred_hit}, {31'd0, eh});
    check(req, pred_target, et);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", {31'd0, pred_valid}, 0);
    check("R10 hit", {31'd0, pred_hit}, 0);
    check("R10 target", pred_target, 0);
    rst_n = 1;
    lookup(32'h15, "R10 empty table", 0, 0);

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v = VEC[i];
      @(negedge clk);
      case (v[73:72])
        OP_TR: begin
          tr_valid = 1; tr_class = v[71:69]; tr_pc = v[68:37];
          tr_thread = v[36]; tr_host = v[35]; tr_target = v[32:1];
        end
        OP_LK: begin
          lk_valid = 1; lk_class = v[71:69]; lk_pc = v[68:37];
          lk_thread = v[36]; lk_host = v[35]; ctl_isolate = v[34]; ctl_restrict = v[33];
        end
        default: ctl_barrier = 1;
      endcase
      @(negedge clk);
      idle();
      if (v[73:72] == OP_LK) begin
        check($sformatf("R1/R2/R3/R5/R8/R11 vec%0d hit", i), {31'd0, pred_hit}, {31'd0, v[0]});
        check($sformatf("R7 vec%0d target", i), pred_target, v[32:1]);
        check($sformatf("R6 vec%0d valid", i), {31'd0, pred_valid}, 1);
      end
    end

    // R6: valid drops on an idle cycle
    @(negedge clk);
    check("R6 idle", {31'd0, pred_valid}, 0);

    // R4: lookup in the barrier cycle misses
    train(3'd1, 32'h15, 0, 0, 32'hAAAA_0001);
    lookup(32'h15, "R8 retrain", 1, 32'hAAAA_0001);
    @(negedge clk);
    lk_valid = 1; lk_class = 3'd1; lk_pc = 32'h15; ctl_barrier = 1;
    @(negedge clk);
    idle();
    check("R4 same-cycle lookup", {31'd0, pred_hit}, 0);

    // R12: barrier beats training
    @(negedge clk);
    tr_valid = 1; tr_class = 3'd2; tr_pc = 32'h17; tr_target = 32'hBEEF; ctl_barrier = 1;
    @(negedge clk);
    idle();
    lookup(32'h17, "R12 barrier over train", 0, 0);

    // R12: lookup with train to same index sees old entry
    train(3'd1, 32'h18, 0, 0, 32'h0000_A000);
    @(negedge clk);
    lk_valid = 1; lk_class = 3'd1; lk_pc = 32'h18; lk_thread = 0; lk_host = 0;
    tr_valid = 1; tr_class = 3'd1; tr_pc = 32'h18; tr_target = 32'h0000_B000;
    @(negedge clk);
    idle();
    check("R12 old content hit", {31'd0, pred_hit}, 1);
    check("R12 old content target", pred_target, 32'h0000_A000);
    lookup(32'h18, "R12 new content", 1, 32'h0000_B000);

    // R10: reset mid-run clears entries
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R10 reset outputs", {31'd0, pred_valid}, 0);
    rst_n = 1;
    lookup(32'h18, "R10 reset clears table", 0, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule